// File: doc/BRIEF.md
# Battery Pack Power-State Controller

This block is the top-level power sequencer of a battery protection device. It tracks four operating states (off, boot, run and nap) and moves between them using supply-valid flags, a nap request bit held by firmware, and a wake pin. From the state, from firmware on/off commands and from two fault flags (overcurrent and over-temperature), it drives the enables of the regulator, the analog bias, the serial link and the current-protection circuits. It also drives the charge FET, the discharge FET and the cell-balancing outputs, and it gives a clear strobe to the register file.

The analog comparators and the measurement chain are outside the block; their results arrive here as synchronous digital flags. The wake pin is asynchronous. It passes through a synchronizer, and either polarity of edge wakes the device. A fault latches a lockout. The lockout keeps the affected outputs off until the fault flag has gone low and firmware has dropped the affected commands, so that the outputs come back only after an explicit re-enable. Every output is a register. The state encoding is off=0, boot=1, run=2, nap=3.

Top module: `pwr_state_ctrl`

## Requirements
- R1: If any bit of `sup_ok` is 0 at a clock edge, `pstate` becomes off (0) at that edge, from any state. In off, `reg_en`, `bias_en`, `link_en`, `prot_en`, both FETs and all of `bal_out` are 0, and `regs_clr` is 1.
- R2: In off with all of `sup_ok` set, the next edge enters boot (1). In boot, `reg_en`, `bias_en`, `link_en`, `prot_en` and `regs_clr` are 1, and both FETs and `bal_out` stay 0 whatever the commands are.
- R3: Boot lasts exactly PUP_CYCLES cycles and then goes to run (2). In run, `regs_clr` is 0, the four enables are 1, and `chg_fet`, `dis_fet` and `bal_out` follow `chg_cmd`, `dis_cmd` and `bal_cmd` one edge later.
- R4: In run, `sleep_req`=1 enters nap (3) on the next edge. In nap only `link_en` is 1; every other output is 0.
- R5: In nap, `sleep_req`=0 returns the block to boot on the next edge.
- R6: In nap, a rising or a falling change on `wake_pin` returns the block to boot on the SYNC_STAGES+1-th edge after the change. A change on `wake_pin` in run has no effect.
- R7: An `oc_flag` seen at an edge turns both FETs off at that edge and leaves `bal_out` as commanded.
- R8: An `ot_flag` seen at an edge turns both FETs and every `bal_out` bit off at that edge.
- R9: A fault lockout persists after its flag clears. The overcurrent lockout releases when `oc_flag`, `chg_cmd` and `dis_cmd` are all 0. The over-temperature lockout releases only when `bal_cmd` is also 0. After release, commands take effect again.
- R10: Reset (`rst`=1, synchronous) gives `pstate`=0, `regs_clr`=1 and all other outputs 0. Entering off also clears both lockouts.
- R11: Supply failure takes priority over a nap exit or a wake edge seen at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_ok | input | NUM_SUP | Per-supply valid flags |
| sleep_req | input | 1 | Nap request bit from firmware |
| wake_pin | input | 1 | Asynchronous wake input, both edges active |
| oc_flag | input | 1 | Overcurrent detected |
| ot_flag | input | 1 | Over-temperature detected |
| chg_cmd | input | 1 | Firmware charge FET on command |
| dis_cmd | input | 1 | Firmware discharge FET on command |
| bal_cmd | input | NUM_BAL | Firmware per-cell balance commands |
| pstate | output | 2 | Current state: 0 off, 1 boot, 2 run, 3 nap |
| reg_en | output | 1 | Regulator enable |
| bias_en | output | 1 | Analog bias enable |
| link_en | output | 1 | Serial link enable |
| prot_en | output | 1 | Current-protection circuits enable |
| regs_clr | output | 1 | Register file clear strobe |
| chg_fet | output | 1 | Charge FET drive |
| dis_fet | output | 1 | Discharge FET drive |
| bal_out | output | NUM_BAL | Cell-balancing drives |

## Verification
The bench goes through all 64 command patterns in run and every combination of the two fault flags. A block that mixed up the two fault scopes would leave the balancing outputs on under over-temperature, or cut them under overcurrent. The bench releases lockouts in partial steps, keeping the balance commands high while the FET commands drop, which exposes a lockout that clears on the flag alone or on too few commands. It also drops each supply on its own, including at the same edge as a nap exit, so that a priority error shows up as boot instead of off, and a lockout that survives off shows up as FETs that stay dark after re-entering run. Both wake polarities are timed to the exact edge, and a wake toggle in run is applied to confirm it has no effect.

// File: rtl/pwr_ctrl_pkg.sv
package pwr_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_BOOT = 2'd1,
    ST_RUN  = 2'd2,
    ST_NAP  = 2'd3
  } pstate_t;

endpackage

// File: rtl/wake_edge_det.sv
module wake_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic edge_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= pin;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[SYNC_STAGES-1];
  end

  assign edge_o = sync_q[SYNC_STAGES-1] ^ last_q;

  // R6: a detected edge reflects a change of the synchronized sample
  p_edge_change_r6: assert property (@(posedge clk) disable iff (rst)
    edge_o |-> (sync_q[SYNC_STAGES-1] != $past(sync_q[SYNC_STAGES-1])));

endmodule

// File: rtl/fault_lock.sv
module fault_lock (
  input  logic clk,
  input  logic rst,
  input  logic clr_all,
  input  logic flag,
  input  logic cmds_idle,
  output logic lock_nxt
);

  logic lock_q;

  assign lock_nxt = clr_all ? 1'b0 : (flag | (lock_q & ~cmds_idle));

  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else     lock_q <= lock_nxt;
  end

  // R9: a flag outside of off always leaves the lockout set
  p_flag_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_all) |=> lock_q);

  // R9: a held lockout with busy commands does not release
  p_lock_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !cmds_idle && !clr_all) |=> lock_q);

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_ctrl_pkg::*;
#(
  parameter int NUM_SUP    = 3,
  parameter int PUP_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SUP-1:0] sup_ok,
  input  logic               sleep_req,
  input  logic               wake_edge,
  output pstate_t            state_q,
  output pstate_t            state_nxt
);

  localparam int CW = $clog2(PUP_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(PUP_CYCLES - 1);

  logic          all_ok;
  logic [CW-1:0] cnt_q;

  assign all_ok = &sup_ok;

  always_comb begin
    state_nxt = state_q;
    if (!all_ok) begin
      state_nxt = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_nxt = ST_BOOT;
        ST_BOOT: if (cnt_q == CNT_LAST) state_nxt = ST_RUN;
        ST_RUN:  if (sleep_req) state_nxt = ST_NAP;
        ST_NAP:  if (!sleep_req || wake_edge) state_nxt = ST_BOOT;
        default: state_nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      if (state_q == ST_BOOT && state_nxt == ST_BOOT) cnt_q <= cnt_q + 1'b1;
      else                                            cnt_q <= '0;
    end
  end

  // R1 / R11: supply failure lands in off, whatever else is pending
  p_sup_fail_r1: assert property (@(posedge clk) disable iff (rst)
    !(&sup_ok) |=> state_q == ST_OFF);

  // R2: valid supplies leave off for boot
  p_boot_enter_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && &sup_ok) |=> state_q == ST_BOOT);

  // R4: nap request in run enters nap
  p_nap_enter_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && sleep_req && &sup_ok) |=> state_q == ST_NAP);

  // R5: clearing the request leaves nap for boot
  p_nap_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NAP && !sleep_req && &sup_ok) |=> state_q == ST_BOOT);

  // R3: run is reached only through boot
  p_run_from_boot_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(state_q) == ST_BOOT);

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_ctrl_pkg::*;
#(
  parameter int NUM_SUP     = 3,
  parameter int NUM_BAL     = 4,
  parameter int PUP_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SUP-1:0] sup_ok,
  input  logic               sleep_req,
  input  logic               wake_pin,
  input  logic               oc_flag,
  input  logic               ot_flag,
  input  logic               chg_cmd,
  input  logic               dis_cmd,
  input  logic [NUM_BAL-1:0] bal_cmd,
  output logic [1:0]         pstate,
  output logic               reg_en,
  output logic               bias_en,
  output logic               link_en,
  output logic               prot_en,
  output logic               regs_clr,
  output logic               chg_fet,
  output logic               dis_fet,
  output logic [NUM_BAL-1:0] bal_out
);

  pstate_t st_q, st_nxt;
  logic    wake_edge;
  logic    oc_lock_nxt, ot_lock_nxt;
  logic    fet_idle, all_idle, in_off;
  logic    run_nxt, pwr_nxt, fet_ok;

  wake_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst(rst), .pin(wake_pin), .edge_o(wake_edge)
  );

  pwr_fsm #(.NUM_SUP(NUM_SUP), .PUP_CYCLES(PUP_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .sup_ok(sup_ok), .sleep_req(sleep_req),
    .wake_edge(wake_edge), .state_q(st_q), .state_nxt(st_nxt)
  );

  assign fet_idle = ~chg_cmd & ~dis_cmd;
  assign all_idle = fet_idle & ~(|bal_cmd);
  assign in_off   = (st_nxt == ST_OFF);

  fault_lock u_oc_lock (
    .clk(clk), .rst(rst), .clr_all(in_off), .flag(oc_flag),
    .cmds_idle(fet_idle), .lock_nxt(oc_lock_nxt)
  );

  fault_lock u_ot_lock (
    .clk(clk), .rst(rst), .clr_all(in_off), .flag(ot_flag),
    .cmds_idle(all_idle), .lock_nxt(ot_lock_nxt)
  );

  assign run_nxt = (st_nxt == ST_RUN);
  assign pwr_nxt = (st_nxt == ST_BOOT) || run_nxt;
  assign fet_ok  = run_nxt & ~oc_lock_nxt & ~ot_lock_nxt;

  assign pstate = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_en   <= 1'b0;
      bias_en  <= 1'b0;
      link_en  <= 1'b0;
      prot_en  <= 1'b0;
      regs_clr <= 1'b1;
      chg_fet  <= 1'b0;
      dis_fet  <= 1'b0;
    end else begin
      reg_en   <= pwr_nxt;
      bias_en  <= pwr_nxt;
      prot_en  <= pwr_nxt;
      link_en  <= (st_nxt != ST_OFF);
      regs_clr <= (st_nxt == ST_OFF) || (st_nxt == ST_BOOT);
      chg_fet  <= fet_ok & chg_cmd;
      dis_fet  <= fet_ok & dis_cmd;
    end
  end

  generate
    for (genvar b = 0; b < NUM_BAL; b++) begin : g_bal
      always_ff @(posedge clk) begin
        if (rst) bal_out[b] <= 1'b0;
        else     bal_out[b] <= run_nxt & ~ot_lock_nxt & bal_cmd[b];
      end
    end
  endgenerate

  // R1 / R10: off is fully quiet with the clear strobe high
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (pstate == 2'd0) |-> (!reg_en && !bias_en && !link_en && !prot_en &&
                          regs_clr && !chg_fet && !dis_fet && bal_out == '0));

  // R2: boot keeps FETs and balancing dark
  p_boot_dark_r2: assert property (@(posedge clk) disable iff (rst)
    (pstate == 2'd1) |-> (!chg_fet && !dis_fet && bal_out == '0 && reg_en && regs_clr));

  // R4: nap keeps only the link alive
  p_nap_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (pstate == 2'd3) |-> (link_en && !reg_en && !bias_en && !prot_en &&
                          !chg_fet && !dis_fet && bal_out == '0));

  // R7: overcurrent drops both FETs at the next edge
  p_oc_off_r7: assert property (@(posedge clk) disable iff (rst)
    oc_flag |=> (!chg_fet && !dis_fet));

  // R8: over-temperature drops FETs and balancing
  p_ot_off_r8: assert property (@(posedge clk) disable iff (rst)
    ot_flag |=> (!chg_fet && !dis_fet && bal_out == '0));

endmodule

// File: tb/pwr_state_ctrl_test.sv
module pwr_state_ctrl_test;

  localparam int NS = 3;
  localparam int NB = 4;
  localparam int PC = 4;
  localparam int SS = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [NS-1:0] sup_ok;
  logic          sleep_req, wake_pin, oc_flag, ot_flag, chg_cmd, dis_cmd;
  logic [NB-1:0] bal_cmd;
  logic [1:0]    pstate;
  logic          reg_en, bias_en, link_en, prot_en, regs_clr, chg_fet, dis_fet;
  logic [NB-1:0] bal_out;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pwr_state_ctrl #(.NUM_SUP(NS), .NUM_BAL(NB), .PUP_CYCLES(PC), .SYNC_STAGES(SS)) uut (
    .clk(clk), .rst(rst), .sup_ok(sup_ok), .sleep_req(sleep_req), .wake_pin(wake_pin),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .chg_cmd(chg_cmd), .dis_cmd(dis_cmd),
    .bal_cmd(bal_cmd), .pstate(pstate), .reg_en(reg_en), .bias_en(bias_en),
    .link_en(link_en), .prot_en(prot_en), .regs_clr(regs_clr), .chg_fet(chg_fet),
    .dis_fet(dis_fet), .bal_out(bal_out)
  );

  // expected output word {state, reg, bias, link, prot, clr, chg, dis, bal}
  function automatic logic [12:0] expv(int st, logic c, logic d, logic [NB-1:0] b);
    case (st)
      0: return {2'd0, 4'b0000, 1'b1, 1'b0, 1'b0, 4'h0};
      1: return {2'd1, 4'b1111, 1'b1, 1'b0, 1'b0, 4'h0};
      2: return {2'd2, 4'b1111, 1'b0, c, d, b};
      default: return {2'd3, 4'b0010, 1'b0, 1'b0, 1'b0, 4'h0};
    endcase
  endfunction

  function automatic logic [12:0] actv();
    return {pstate, reg_en, bias_en, link_en, prot_en, regs_clr, chg_fet, dis_fet, bal_out};
  endfunction

  task automatic chk(string req, logic [12:0] exp);
    logic [12:0] a;
    a = actv();
    total++;
    if (a !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, a, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_cmd(logic c, logic d, logic [NB-1:0] b);
    chg_cmd = c; dis_cmd = d; bal_cmd = b;
  endtask

  // from off with supplies good: boot for PC cycles, then run
  task automatic boot_to_run(string req);
    sup_ok = '1;
    for (int i = 0; i < PC; i++) begin
      tick();
      chk(req, expv(1, 0, 0, 0));
    end
    tick();
    chk(req, expv(2, chg_cmd, dis_cmd, bal_cmd));
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; sup_ok = '0; sleep_req = 0; wake_pin = 0;
    oc_flag = 0; ot_flag = 0; set_cmd(1, 1, '1);
    repeat (3) tick();
    chk("R10 reset", expv(0, 0, 0, 0));
    rst = 0;
    tick();
    chk("R1 no supply stays off", expv(0, 0, 0, 0));

    // R2/R3 boot with commands already high, then run
    boot_to_run("R2 R3 boot sequence");

    // R3 sweep every command pattern in run
    for (int v = 0; v < 64; v++) begin
      set_cmd(v[5], v[4], v[3:0]);
      tick();
      chk("R3 command follow", expv(2, v[5], v[4], v[3:0]));
    end

    // R7 / R8 every fault combination
    for (int f = 0; f < 4; f++) begin
      set_cmd(1, 1, '1);
      oc_flag = f[0]; ot_flag = f[1];
      tick();
      chk(f[1] ? "R8 fault sweep" : "R7 fault sweep",
          expv(2, !(f[0] | f[1]), !(f[0] | f[1]), f[1] ? 4'h0 : 4'hF));
      oc_flag = 0; ot_flag = 0; set_cmd(0, 0, '0);
      tick();
      chk("R9 release", expv(2, 0, 0, 0));
    end

    // R9 overcurrent lockout holds after flag clears
    set_cmd(1, 1, 4'h5);
    oc_flag = 1; tick();
    chk("R7 oc off", expv(2, 0, 0, 4'h5));
    oc_flag = 0; tick();
    chk("R9 oc held", expv(2, 0, 0, 4'h5));
    set_cmd(0, 0, 4'h5); tick();
    set_cmd(1, 1, 4'h5); tick();
    chk("R9 oc re-enable", expv(2, 1, 1, 4'h5));

    // R9 over-temperature lockout needs balancing idle too
    ot_flag = 1; tick();
    chk("R8 ot off", expv(2, 0, 0, 0));
    ot_flag = 0; set_cmd(0, 0, 4'h5); tick();
    set_cmd(1, 1, 4'h5); tick();
    chk("R9 ot held with bal busy", expv(2, 0, 0, 0));
    set_cmd(0, 0, 4'h0); tick();
    set_cmd(1, 1, 4'h5); tick();
    chk("R9 ot re-enable", expv(2, 1, 1, 4'h5));

    // R6 wake toggle in run has no effect
    wake_pin = 1;
    for (int i = 0; i < SS + 2; i++) begin
      tick();
      chk("R6 wake ignored in run", expv(2, 1, 1, 4'h5));
    end

    // R4 enter nap, R5 leave by clearing the request
    sleep_req = 1; tick();
    chk("R4 nap", expv(3, 0, 0, 0));
    sleep_req = 0; tick();
    chk("R5 nap exit", expv(1, 0, 0, 0));
    for (int i = 1; i < PC; i++) tick();
    tick();
    chk("R5 back to run", expv(2, 1, 1, 4'h5));

    // R6 falling wake edge (pin now high) exits nap after SS+1 edges
    sleep_req = 1; tick();
    chk("R4 nap again", expv(3, 0, 0, 0));
    wake_pin = 0;
    for (int i = 0; i < SS; i++) begin
      tick();
      chk("R6 fall pending", expv(3, 0, 0, 0));
    end
    tick();
    chk("R6 fall wake", expv(1, 0, 0, 0));
    for (int i = 1; i < PC; i++) tick();
    tick();
    chk("R6 run after wake", expv(2, 1, 1, 4'h5));
    tick();
    chk("R4 request still set", expv(3, 0, 0, 0));

    // R6 rising wake edge
    wake_pin = 1;
    for (int i = 0; i < SS; i++) begin
      tick();
      chk("R6 rise pending", expv(3, 0, 0, 0));
    end
    tick();
    chk("R6 rise wake", expv(1, 0, 0, 0));
    sleep_req = 0;
    for (int i = 1; i < PC; i++) tick();
    tick();
    chk("R3 run", expv(2, 1, 1, 4'h5));

    // R11 supply drop together with nap exit
    sleep_req = 1; tick();
    chk("R4 nap for R11", expv(3, 0, 0, 0));
    sleep_req = 0; sup_ok = 3'b101; tick();
    chk("R11 supply beats nap exit", expv(0, 0, 0, 0));

    // R1 / R10 each supply alone, lockout cleared by off
    for (int s = 0; s < NS; s++) begin
      set_cmd(1, 1, 4'hA);
      boot_to_run("R1 restart");
      oc_flag = 1; ot_flag = 1; tick();
      chk("R8 lock before drop", expv(2, 0, 0, 0));
      oc_flag = 0; ot_flag = 0;
      sup_ok = '1; sup_ok[s] = 1'b0; tick();
      chk("R1 single supply fail", expv(0, 0, 0, 0));
    end
    boot_to_run("R10 lockout cleared by off");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule